// File: doc/BRIEF.md
# Double-Buffered Bulk-IN Endpoint Transmit Buffer

This block is the transmit store for one bulk-IN endpoint of a USB device controller. It holds two byte-wide banks. At any moment one bank is owned by the CPU, which fills it through a write-only byte port. The other bank is owned by the serial interface engine, which drains it when the host sends an IN token. The two banks trade owners on their own, with no command from software. A trade happens only when the engine's bank holds no pending packet and the CPU's bank is complete. The CPU's bank is complete when it is full, or when software has marked the end of the data.

Software fills the CPU bank one byte after another. The write position advances inside the block. If the packet is shorter than a full bank, software raises the end-of-data strobe. This gives a short packet. If software clears the bank and then raises end-of-data, a zero-length packet is queued.

When an IN token arrives, the block answers in the next cycle. It either offers the pending packet or, if sending is disabled or nothing is pending, answers with NAK. The engine reads the bytes in order and then acknowledges a successful transmission. The acknowledge frees the engine bank and sets a transmit-done flag. That flag drives either a CPU interrupt or a DMA request, chosen by a select input.

Top module: `usb_bulkin_pingpong`

## Requirements
- R1: After reset nothing is pending: data_present, end_pending, done_flag, ovf_flag, irq and dma_req are 0, pkt_len is 0, and an IN token gets resp_nak.
- R2: cpu_rdata always reads 0x00, whatever has been written.
- R3: Each accepted CPU write stores its byte at the next position of the CPU bank. After DEPTH writes the bank passes to the engine side by itself, provided that side is empty. The engine then reads the bytes in write order with pkt_len equal to DEPTH.
- R4: While the engine bank holds a pending packet, no swap takes place, even when the CPU bank is full. A full CPU bank is handed over in the second cycle after a successful transmit acknowledge.
- R5: A cpu_end pulse after N writes, with N less than DEPTH, hands over a short packet with pkt_len equal to N. end_pending reads 0 once the handover has taken place.
- R6: A cpu_clear followed by cpu_end hands over a zero-length packet: data_present is 1 and pkt_len is 0.
- R7: in_token gets exactly one of resp_send or resp_nak in the following cycle. resp_send is given only when tx_enable is 1 and a packet is pending.
- R8: tx_ack while a packet is pending drops data_present and sets done_flag in the next cycle.
- R9: While done_flag is 1, irq is 1 when req_sel is 0, and dma_req is 1 when req_sel is 1. The other request stays 0.
- R10: A write to a full CPU bank is ignored and sets ovf_flag. The packet later handed over contains only the original DEPTH bytes.
- R11: clr_done clears done_flag and clr_ovf clears ovf_flag. cpu_clear discards bytes already written to the CPU bank, so the next write lands at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read value of the data port, always zero |
| cpu_end | input | 1 | End-of-data strobe for the CPU bank |
| cpu_clear | input | 1 | Discard CPU bank contents |
| tx_enable | input | 1 | Permits sending; otherwise IN tokens get NAK |
| req_sel | input | 1 | 0: interrupt on transmit-done, 1: DMA request |
| clr_done | input | 1 | Write-one-to-clear of done_flag |
| clr_ovf | input | 1 | Write-one-to-clear of ovf_flag |
| in_token | input | 1 | IN token received for this endpoint |
| resp_send | output | 1 | Answer: send pending packet |
| resp_nak | output | 1 | Answer: NAK |
| pkt_len | output | 7 | Length of pending packet in bytes |
| eng_rd | input | 1 | Engine byte read strobe |
| eng_rdata | output | 8 | Current engine-side byte |
| tx_ack | input | 1 | Transmission succeeded |
| data_present | output | 1 | Engine bank holds a pending packet |
| end_pending | output | 1 | End-of-data marked on CPU bank |
| done_flag | output | 1 | Transmit-done status |
| ovf_flag | output | 1 | Write to full bank seen |
| irq | output | 1 | CPU interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with DEPTH set to 4. This makes a full bank only four writes long. As a result, every packet length from zero to full can be swept under both request selections. The same small depth makes the overflow and deferred-handover cases short enough to drive byte by byte. Expected bytes come from a simple arithmetic pattern of packet number and position, so every byte the engine reads is checked.

// File: rtl/bip_pkg.sv
package bip_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_id_e;
endpackage

// File: rtl/bip_rst_sync.sv
module bip_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bip_bank.sv
module bip_bank
  import bip_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  byte_t         wr_data,
  input  logic [AW-1:0] rd_addr,
  output byte_t         rd_data
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/bip_token.sv
module bip_token (
  input  logic clk,
  input  logic rst_n,
  input  logic in_token,
  input  logic tx_enable,
  input  logic pending,
  output logic resp_send,
  output logic resp_nak
);
  logic send_d, nak_d, send_q, nak_q;

  always_comb begin
    send_d = in_token && tx_enable && pending;
    nak_d  = in_token && !(tx_enable && pending);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q <= 1'b0;
      nak_q  <= 1'b0;
    end else begin
      send_q <= send_d;
      nak_q  <= nak_d;
    end
  end

  assign resp_send = send_q;
  assign resp_nak  = nak_q;

  // R7: every token is answered exactly once in the next cycle
  a_r7_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    in_token |=> (resp_send ^ resp_nak));
  // R7: sending is never offered without permission
  a_r7_send_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !tx_enable) |=> !resp_send);
endmodule

// File: rtl/bip_ctrl.sv
module bip_ctrl
  import bip_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_end,
  input  logic          cpu_clear,
  input  logic          eng_rd,
  input  logic          tx_ack,
  input  logic          clr_done,
  input  logic          clr_ovf,
  output bank_id_e      cpu_bank,
  output logic          wr_accept,
  output logic [CW-1:0] wr_pos,
  output logic [CW-1:0] rd_pos,
  output logic          eng_full,
  output logic [CW-1:0] eng_len,
  output logic          end_flag,
  output logic          done,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  bank_id_e      bank_q, bank_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] rptr_q, rptr_d;
  logic          efull_q, efull_d;
  logic          end_q, end_d;
  logic          done_q, done_d;
  logic          ovf_q, ovf_d;
  logic          cpu_full, cpu_busy, swap, ack_ok, rd_ok;

  always_comb begin
    cpu_full  = (cnt_q == FULL_CNT);
    wr_accept = cpu_wr && !cpu_full;
    cpu_busy  = cpu_wr || cpu_end || cpu_clear;
    swap      = !efull_q && (cpu_full || end_q) && !cpu_busy;
    ack_ok    = tx_ack && efull_q;
    rd_ok     = eng_rd && efull_q && (rptr_q < len_q);

    bank_d = bank_q;
    if (swap) bank_d = (bank_q == BANK_A) ? BANK_B : BANK_A;

    cnt_d = cnt_q;
    if (swap || cpu_clear) cnt_d = '0;
    else if (wr_accept)    cnt_d = cnt_q + 1'b1;

    end_d = end_q;
    if (swap)           end_d = 1'b0;
    else if (cpu_end)   end_d = 1'b1;
    else if (cpu_clear) end_d = 1'b0;

    efull_d = efull_q;
    if (swap)        efull_d = 1'b1;
    else if (ack_ok) efull_d = 1'b0;

    len_d = swap ? cnt_q : len_q;

    rptr_d = rptr_q;
    if (swap)       rptr_d = '0;
    else if (rd_ok) rptr_d = rptr_q + 1'b1;

    done_d = done_q;
    if (ack_ok)        done_d = 1'b1;
    else if (clr_done) done_d = 1'b0;

    ovf_d = ovf_q;
    if (cpu_wr && cpu_full) ovf_d = 1'b1;
    else if (clr_ovf)       ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= BANK_A;
      cnt_q   <= '0;
      len_q   <= '0;
      rptr_q  <= '0;
      efull_q <= 1'b0;
      end_q   <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      rptr_q  <= rptr_d;
      efull_q <= efull_d;
      end_q   <= end_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
    end
  end

  assign cpu_bank = bank_q;
  assign wr_pos   = cnt_q;
  assign rd_pos   = rptr_q;
  assign eng_full = efull_q;
  assign eng_len  = len_q;
  assign end_flag = end_q;
  assign done     = done_q;
  assign ovf      = ovf_q;

  // R4: roles hold while the engine bank is occupied
  a_r4_hold_roles: assert property (@(posedge clk) disable iff (!rst_n)
    efull_q |=> $stable(bank_q));
  // R5: a handover leaves an empty CPU bank with end-of-data cleared
  a_r5_end_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> (!end_q && cnt_q == '0 && efull_q));
  // R8: acknowledge frees the engine bank and flags completion
  a_r8_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && efull_q) |=> (done_q && !efull_q));
  // R10: a write into a full bank is dropped and flagged
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_full && !cpu_clear) |=> (ovf_q && cnt_q == FULL_CNT));
  // R3: fill level never exceeds the bank size
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= FULL_CNT) && (len_q <= FULL_CNT));
endmodule

// File: rtl/usb_bulkin_pingpong.sv
module usb_bulkin_pingpong
  import bip_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          cpu_end,
  input  logic          cpu_clear,
  input  logic          tx_enable,
  input  logic          req_sel,
  input  logic          clr_done,
  input  logic          clr_ovf,
  input  logic          in_token,
  output logic          resp_send,
  output logic          resp_nak,
  output logic [CW-1:0] pkt_len,
  input  logic          eng_rd,
  output logic [7:0]    eng_rdata,
  input  logic          tx_ack,
  output logic          data_present,
  output logic          end_pending,
  output logic          done_flag,
  output logic          ovf_flag,
  output logic          irq,
  output logic          dma_req
);
  logic          rst_n_s;
  bank_id_e      cpu_bank;
  logic          wr_accept, eng_full, end_flag, done, ovf;
  logic [CW-1:0] wr_pos, rd_pos, eng_len;
  byte_t         bank_rd [2];

  bip_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bip_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cpu_wr    (cpu_wr),
    .cpu_end   (cpu_end),
    .cpu_clear (cpu_clear),
    .eng_rd    (eng_rd),
    .tx_ack    (tx_ack),
    .clr_done  (clr_done),
    .clr_ovf   (clr_ovf),
    .cpu_bank  (cpu_bank),
    .wr_accept (wr_accept),
    .wr_pos    (wr_pos),
    .rd_pos    (rd_pos),
    .eng_full  (eng_full),
    .eng_len   (eng_len),
    .end_flag  (end_flag),
    .done      (done),
    .ovf       (ovf)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_accept && (cpu_bank == bank_id_e'(b));
    bip_bank #(.DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wr_en   (bank_we),
      .wr_addr (wr_pos[AW-1:0]),
      .wr_data (cpu_wdata),
      .rd_addr (rd_pos[AW-1:0]),
      .rd_data (bank_rd[b])
    );
  end

  bip_token u_token (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_token  (in_token),
    .tx_enable (tx_enable),
    .pending   (eng_full),
    .resp_send (resp_send),
    .resp_nak  (resp_nak)
  );

  assign cpu_rdata    = 8'h00;
  assign eng_rdata    = (cpu_bank == BANK_A) ? bank_rd[1] : bank_rd[0];
  assign pkt_len      = eng_full ? eng_len : '0;
  assign data_present = eng_full;
  assign end_pending  = end_flag;
  assign done_flag    = done;
  assign ovf_flag     = ovf;
  assign irq          = done && !req_sel;
  assign dma_req      = done && req_sel;

  // R9: never both request kinds at once
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(irq && dma_req));
  // R1: an idle engine side reports zero length
  a_r1_idle_len: assert property (@(posedge clk) disable iff (!rst_n_s)
    !data_present |-> (pkt_len == '0));
endmodule

// File: tb/test_usb_bulkin_pingpong.sv
module test_usb_bulkin_pingpong;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_end = 1'b0, cpu_clear = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic tx_enable = 1'b0, req_sel = 1'b0, clr_done = 1'b0, clr_ovf = 1'b0;
  logic in_token = 1'b0, eng_rd = 1'b0, tx_ack = 1'b0;
  logic [7:0] cpu_rdata, eng_rdata;
  logic resp_send, resp_nak, data_present, end_pending, done_flag, ovf_flag, irq, dma_req;
  logic [CW-1:0] pkt_len;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  usb_bulkin_pingpong #(.DEPTH(DEPTH)) i_usb_bulkin_pingpong (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_end(cpu_end), .cpu_clear(cpu_clear),
    .tx_enable(tx_enable), .req_sel(req_sel), .clr_done(clr_done),
    .clr_ovf(clr_ovf), .in_token(in_token), .resp_send(resp_send),
    .resp_nak(resp_nak), .pkt_len(pkt_len), .eng_rd(eng_rd),
    .eng_rdata(eng_rdata), .tx_ack(tx_ack), .data_present(data_present),
    .end_pending(end_pending), .done_flag(done_flag), .ovf_flag(ovf_flag),
    .irq(irq), .dma_req(dma_req)
  );

  function automatic logic [7:0] pat(int p, int i);
    return 8'(p * 16 + i + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    cpu_wdata = b; cpu_wr = 1'b1; step(1); cpu_wr = 1'b0;
  endtask

  task automatic end_pkt();
    cpu_end = 1'b1; step(1); cpu_end = 1'b0;
  endtask

  task automatic clear_bank();
    cpu_clear = 1'b1; step(1); cpu_clear = 1'b0;
  endtask

  task automatic ack();
    tx_ack = 1'b1; step(1); tx_ack = 1'b0;
  endtask

  task automatic token(string req, logic exp_send);
    in_token = 1'b1; step(1); in_token = 1'b0;
    check(req, {resp_send, resp_nak}, exp_send ? 2 : 1);
  endtask

  task automatic read_pkt(string req, int p, int len);
    for (int i = 0; i < len; i++) begin
      check(req, eng_rdata, pat(p, i));
      eng_rd = 1'b1; step(1); eng_rd = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1 reset state
    check("R1 present", data_present, 0);
    check("R1 len", pkt_len, 0);
    check("R1 flags", {end_pending, done_flag, ovf_flag, irq, dma_req}, 0);
    tx_enable = 1'b1;
    token("R1 nak", 1'b0);
    check("R2 rdata", cpu_rdata, 0);

    // R3 R5 R6 R7 R8 R9 R11: sweep every length under both request kinds
    for (int sel = 0; sel < 2; sel++) begin
      for (int n = 0; n <= int'(DEPTH); n++) begin
        int p;
        p = sel * 5 + n;
        req_sel = sel[0];
        clear_bank();
        for (int i = 0; i < n; i++) wr(pat(p, i));
        check("R2 rdata", cpu_rdata, 0);
        if (n < int'(DEPTH)) end_pkt();
        step(2);
        check(n == 0 ? "R6 zlp present" : "R3 R5 present", data_present, 1);
        check(n == 0 ? "R6 zlp len" : "R3 R5 len", pkt_len, n);
        check("R5 end selfclear", end_pending, 0);
        tx_enable = 1'b0;
        token("R7 disabled nak", 1'b0);
        tx_enable = 1'b1;
        token("R7 send", 1'b1);
        read_pkt("R3 data order", p, n);
        ack();
        check("R8 freed", data_present, 0);
        check("R8 done", done_flag, 1);
        check("R9 irq", irq, sel == 0);
        check("R9 dma", dma_req, sel == 1);
        token("R7 empty nak", 1'b0);
        clr_done = 1'b1; step(1); clr_done = 1'b0;
        check("R11 done clear", done_flag, 0);
      end
    end

    // R4 R10: second full bank waits; overflow byte dropped
    for (int i = 0; i < int'(DEPTH); i++) wr(pat(10, i));
    step(2);
    check("R4 first present", data_present, 1);
    for (int i = 0; i < int'(DEPTH); i++) wr(pat(11, i));
    wr(8'hEE);
    check("R10 ovf", ovf_flag, 1);
    step(3);
    check("R4 held len", pkt_len, DEPTH);
    read_pkt("R4 first data", 10, DEPTH);
    ack();
    check("R4 gap", data_present, 0);
    step(1);
    check("R4 handover", data_present, 1);
    check("R10 len", pkt_len, DEPTH);
    read_pkt("R10 data", 11, DEPTH);
    clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
    check("R11 ovf clear", ovf_flag, 0);
    ack();
    clr_done = 1'b1; step(1); clr_done = 1'b0;

    // R11: clear discards earlier bytes
    wr(8'h55); wr(8'h66);
    clear_bank();
    wr(pat(12, 0));
    end_pkt();
    step(2);
    check("R11 clear len", pkt_len, 1);
    read_pkt("R11 clear data", 12, 1);
    ack();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule